// File: doc/BRIEF.md
# Per-Word SEC-DED Codec with Error Log and Fault Injection

This block guards every 32-bit data word on its way to and from storage with an 8-bit check field, so each stored word is 40 bits wide. On the write path it builds the check field in one registered stage. Before the word leaves, it can XOR a diagnostic mask into the word so that software can plant known faults in storage. On the read path it computes a syndrome, repairs any single flipped bit among the 40, and marks any two-bit fault as beyond repair. Both paths have a latency of one clock.

Every error seen on the read path goes to a small word-addressed register file. The file holds sticky error flags, the address and syndrome of the failing word, the interrupt enables, and the injection mask. A level interrupt follows the sticky flags through their enables. Software clears the flags by writing ones to them.

Top module: `ecc_word_codec`

## Requirements
- R1: One cycle after `wr_valid`, `wr_code_valid` is high. `wr_code[31:0]` carries the data. `wr_code[38:32]` is the XOR of the 7-bit columns of all data bits that are set, where data bit j owns the (j+1)-th smallest integer of 3 or more that is not a power of two. `wr_code[39]` makes the even parity of all 40 bits. This holds when no injection mask is pending.
- R2: One cycle after `rd_valid`, a read of a valid codeword gives the data unchanged on `rd_out_data`, with `rd_out_corr` and `rd_out_uncorr` both low.
- R3: A read word that differs from a codeword in exactly one of its 40 bits gives the repaired data and raises `rd_out_corr`.
- R4: A read word that differs from a codeword in exactly two bits raises `rd_out_uncorr`, leaves `rd_out_corr` low, and passes the raw data bits through.
- R5: Register 1 (status) holds a sticky flag for corrected errors in bit 0 and one for uncorrectable errors in bit 1. Each flag is set one cycle after the matching read result. Writing a one to a flag clears it. An error event in the same cycle as the clear wins.
- R6: On an error event, register 2 takes the read address and register 3 takes the syndrome {overall parity mismatch, 7-bit check mismatch}. This happens only while the uncorrectable flag is clear, so the first uncorrectable error is kept.
- R7: Register 0 bit 0 enables the interrupt for corrected errors and bit 1 enables it for uncorrectable errors. `irq` is the OR of each sticky flag ANDed with its enable.
- R8: Register 4 loads mask bits 31:0 and register 5 bits 7:0 load mask bits 39:32. The next write XORs the mask into its code, and the mask then reads back as zero. A mask write in the same cycle as a write leaves the new mask pending, and that write uses the old mask.
- R9: After reset, all outputs, the status, the log and the mask are zero. Register addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write data is present |
| wr_data | input | 32 | Data word to encode |
| wr_code_valid | output | 1 | Encoded word is present |
| wr_code | output | 40 | Encoded word, with the injection mask applied |
| rd_valid | input | 1 | Stored word is present for decoding |
| rd_addr | input | 16 | Word address, used for logging |
| rd_code | input | 40 | Stored word as read back |
| rd_out_valid | output | 1 | Decoded result is present |
| rd_out_data | output | 32 | Repaired data |
| rd_out_corr | output | 1 | A single-bit error was repaired |
| rd_out_uncorr | output | 1 | An error could not be repaired |
| irq | output | 1 | Enabled error interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |

## Verification
A wrong check column or a wrong parity bit shows on `wr_code` in the first encoded cycle. On reads, the same fault shows as a clean word that gets flagged, or as a flipped bit that is not repaired. Both show on the cycle after the read. A stale sticky flag, a log entry that is overwritten too early, or a mask that does not clear itself shows on `reg_rdata` or `irq` within one or two cycles of the event that caused it. The bench compares every output with its model on every clock, so it catches the first wrong cycle.

// File: rtl/ecc_codec_pkg.sv
package ecc_codec_pkg;

    localparam int DATA_W = 32;
    localparam int HAM_W  = 7;
    localparam int CODE_W = DATA_W + HAM_W + 1;
    localparam int REG_AW = 3;
    localparam int REG_W  = 32;
    localparam int SYN_W  = HAM_W + 1;

    localparam logic [REG_AW-1:0] RG_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] RG_STAT  = 3'd1;
    localparam logic [REG_AW-1:0] RG_LADDR = 3'd2;
    localparam logic [REG_AW-1:0] RG_LSYN  = 3'd3;
    localparam logic [REG_AW-1:0] RG_MLO   = 3'd4;
    localparam logic [REG_AW-1:0] RG_MHI   = 3'd5;

    // Column table: data bit j gets the j-th non-power-of-two value >= 3
    function automatic logic [DATA_W*HAM_W-1:0] build_columns();
        logic [DATA_W*HAM_W-1:0] tbl;
        int n;
        tbl = '0;
        n = 0;
        for (int k = 3; k < (1 << HAM_W); k++) begin
            if (((k & (k - 1)) != 0) && (n < DATA_W)) begin
                tbl[n*HAM_W +: HAM_W] = k[HAM_W-1:0];
                n++;
            end
        end
        return tbl;
    endfunction

    localparam logic [DATA_W*HAM_W-1:0] COLUMNS = build_columns();

    function automatic logic [HAM_W-1:0] column_of(input int j);
        return COLUMNS[j*HAM_W +: HAM_W];
    endfunction

    function automatic logic [HAM_W-1:0] check_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        h = '0;
        for (int j = 0; j < DATA_W; j++) begin
            if (d[j]) h = h ^ column_of(j);
        end
        return h;
    endfunction

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } enc_state_t;

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CODE_W-1:0] inj_mask,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code
);

    localparam int BODY_W = DATA_W + HAM_W;

    enc_state_t s_d, s_q;
    logic [BODY_W-1:0] body;

    always_comb begin
        s_d       = s_q;
        body      = {check_bits(in_data), in_data};
        s_d.valid = in_valid;
        if (in_valid) begin
            s_d.code = {^body, body} ^ inj_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.valid;
    assign out_code  = s_q.code;

    // R1: with no mask pending, every emitted word has even parity
    p_even_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && ($past(inj_mask) == '0)) |-> (^out_code == 1'b0));

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_codec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_corr,
    output logic              out_uncorr,
    output logic [ADDR_W-1:0] out_addr,
    output logic [SYN_W-1:0]  out_syn
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              corr;
        logic              uncorr;
        logic [ADDR_W-1:0] addr;
        logic [SYN_W-1:0]  syn;
    } dec_state_t;

    dec_state_t s_d, s_q;

    logic [DATA_W-1:0] raw_data;
    logic [HAM_W-1:0]  raw_chk;
    logic [HAM_W-1:0]  syn;
    logic              par_bad;
    logic [DATA_W-1:0] data_hit;
    logic [HAM_W-1:0]  chk_hit;
    logic              located;

    assign raw_data = in_code[DATA_W-1:0];
    assign raw_chk  = in_code[DATA_W +: HAM_W];
    assign syn      = check_bits(raw_data) ^ raw_chk;
    assign par_bad  = ^in_code;

    // One comparator per data bit against its column
    for (genvar j = 0; j < DATA_W; j++) begin : g_data_hit
        assign data_hit[j] = (syn == column_of(j));
    end

    // Check-bit positions carry single-bit columns
    for (genvar i = 0; i < HAM_W; i++) begin : g_chk_hit
        assign chk_hit[i] = (syn == HAM_W'(1 << i));
    end

    assign located = (|data_hit) | (|chk_hit) | (syn == '0);

    always_comb begin
        s_d        = s_q;
        s_d.valid  = in_valid;
        s_d.corr   = 1'b0;
        s_d.uncorr = 1'b0;
        if (in_valid) begin
            s_d.addr = in_addr;
            s_d.syn  = {par_bad, syn};
            if (par_bad && located) begin
                s_d.data = raw_data ^ data_hit;
                s_d.corr = 1'b1;
            end else begin
                s_d.data   = raw_data;
                s_d.uncorr = (par_bad && !located) || (!par_bad && (syn != '0));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid  = s_q.valid;
    assign out_data   = s_q.data;
    assign out_corr   = s_q.corr;
    assign out_uncorr = s_q.uncorr;
    assign out_addr   = s_q.addr;
    assign out_syn    = s_q.syn;

    // R4: a result is never both repaired and unrepairable
    p_one_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_corr && out_uncorr));

    // R2: a word with no mismatch at all is reported clean
    p_clean_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_syn == '0)) |-> (!out_corr && !out_uncorr));

endmodule

// File: rtl/ecc_regs.sv
module ecc_regs
    import ecc_codec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_corr,
    input  logic              ev_uncorr,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [SYN_W-1:0]  ev_syn,
    input  logic              wr_fire,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [CODE_W-1:0] inj_mask,
    output logic              irq,
    output logic [REG_W-1:0]  reg_rdata
);

    localparam int HI_W = CODE_W - REG_W;

    typedef struct packed {
        logic [1:0]        ctrl;
        logic              st_corr;
        logic              st_uncorr;
        logic [ADDR_W-1:0] laddr;
        logic [SYN_W-1:0]  lsyn;
        logic [CODE_W-1:0] mask;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic [1:0] w1c;
    logic       ev_any;

    always_comb begin
        s_d    = s_q;
        w1c    = (reg_we && (reg_addr == RG_STAT)) ? reg_wdata[1:0] : 2'b00;
        ev_any = ev_valid && (ev_corr || ev_uncorr);

        s_d.st_corr   = (s_q.st_corr   & ~w1c[0]) | (ev_valid & ev_corr);
        s_d.st_uncorr = (s_q.st_uncorr & ~w1c[1]) | (ev_valid & ev_uncorr);

        if (ev_any && !s_q.st_uncorr) begin
            s_d.laddr = ev_addr;
            s_d.lsyn  = ev_syn;
        end

        if (reg_we && (reg_addr == RG_CTRL)) s_d.ctrl = reg_wdata[1:0];

        if (wr_fire) s_d.mask = '0;
        if (reg_we && (reg_addr == RG_MLO)) s_d.mask[REG_W-1:0]      = reg_wdata;
        if (reg_we && (reg_addr == RG_MHI)) s_d.mask[CODE_W-1:REG_W] = reg_wdata[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_addr)
            RG_CTRL:  reg_rdata = {{(REG_W-2){1'b0}}, s_q.ctrl};
            RG_STAT:  reg_rdata = {{(REG_W-2){1'b0}}, s_q.st_uncorr, s_q.st_corr};
            RG_LADDR: reg_rdata = {{(REG_W-ADDR_W){1'b0}}, s_q.laddr};
            RG_LSYN:  reg_rdata = {{(REG_W-SYN_W){1'b0}}, s_q.lsyn};
            RG_MLO:   reg_rdata = s_q.mask[REG_W-1:0];
            RG_MHI:   reg_rdata = {{(REG_W-HI_W){1'b0}}, s_q.mask[CODE_W-1:REG_W]};
            default:  reg_rdata = '0;
        endcase
    end

    assign inj_mask = s_q.mask;
    assign irq      = (s_q.st_corr & s_q.ctrl[0]) | (s_q.st_uncorr & s_q.ctrl[1]);

    // R5: a corrected-error flag stays set until cleared by a written one
    p_status_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.st_corr) && !($past(reg_we) && ($past(reg_addr) == RG_STAT)
            && $past(reg_wdata[0]))) |-> s_q.st_corr);

    // R6: while an uncorrectable error is held, the logged address is frozen
    p_log_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s_q.st_uncorr) |-> $stable(s_q.laddr));

    // R7: the interrupt only rises after an error event or an enable write
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ev_valid) || $past(reg_we)));

    // R8: a mask is consumed by the write it was applied to
    p_mask_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_fire) && !$past(reg_we)) |-> (inj_mask == '0));

endmodule

// File: rtl/ecc_word_codec.sv
module ecc_word_codec
    import ecc_codec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_code_valid,
    output logic [CODE_W-1:0] wr_code,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CODE_W-1:0] rd_code,
    output logic              rd_out_valid,
    output logic [DATA_W-1:0] rd_out_data,
    output logic              rd_out_corr,
    output logic              rd_out_uncorr,
    output logic              irq,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);

    logic [CODE_W-1:0] inj_mask;
    logic [ADDR_W-1:0] ev_addr;
    logic [SYN_W-1:0]  ev_syn;

    ecc_enc u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (wr_valid),
        .in_data   (wr_data),
        .inj_mask  (inj_mask),
        .out_valid (wr_code_valid),
        .out_code  (wr_code)
    );

    ecc_dec #(.ADDR_W(ADDR_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (rd_valid),
        .in_addr    (rd_addr),
        .in_code    (rd_code),
        .out_valid  (rd_out_valid),
        .out_data   (rd_out_data),
        .out_corr   (rd_out_corr),
        .out_uncorr (rd_out_uncorr),
        .out_addr   (ev_addr),
        .out_syn    (ev_syn)
    );

    ecc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (rd_out_valid),
        .ev_corr   (rd_out_corr),
        .ev_uncorr (rd_out_uncorr),
        .ev_addr   (ev_addr),
        .ev_syn    (ev_syn),
        .wr_fire   (wr_valid),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .inj_mask  (inj_mask),
        .irq       (irq),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: tb/sim_ecc_word_codec.sv
module sim_ecc_word_codec;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid;
    logic [31:0] wr_data;
    logic        wr_code_valid;
    logic [39:0] wr_code;
    logic        rd_valid;
    logic [15:0] rd_addr;
    logic [39:0] rd_code;
    logic        rd_out_valid;
    logic [31:0] rd_out_data;
    logic        rd_out_corr;
    logic        rd_out_uncorr;
    logic        irq;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_word_codec u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_code_valid(wr_code_valid), .wr_code(wr_code),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_code(rd_code),
        .rd_out_valid(rd_out_valid), .rd_out_data(rd_out_data),
        .rd_out_corr(rd_out_corr), .rd_out_uncorr(rd_out_uncorr),
        .irq(irq),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // ---------------- behavioural reference ----------------
    function automatic bit is_pow2(input int k);
        return (k > 0) && ((k & (k - 1)) == 0);
    endfunction

    function automatic logic [6:0] bench_col(input int j);
        int seen = 0;
        for (int k = 3; k < 128; k++) begin
            if (!is_pow2(k)) begin
                if (seen == j) return k[6:0];
                seen++;
            end
        end
        return 7'd0;
    endfunction

    function automatic logic [6:0] bench_ham(input logic [31:0] d);
        logic [6:0] h = 7'd0;
        for (int j = 0; j < 32; j++) if (d[j]) h ^= bench_col(j);
        return h;
    endfunction

    function automatic logic [39:0] bench_enc(input logic [31:0] d);
        logic [38:0] b;
        b = {bench_ham(d), d};
        return {^b, b};
    endfunction

    logic        m_wv, m_rv, m_rc, m_ru;
    logic [39:0] m_wcode, m_mask;
    logic [31:0] m_rdata;
    logic [15:0] m_raddr, m_laddr;
    logic [7:0]  m_rsyn, m_lsyn;
    logic [1:0]  m_ctrl, m_st;
    bit          m_inj_used;

    task automatic model_reset();
        m_wv = 0; m_rv = 0; m_rc = 0; m_ru = 0;
        m_wcode = '0; m_mask = '0; m_rdata = '0;
        m_raddr = '0; m_laddr = '0; m_rsyn = '0; m_lsyn = '0;
        m_ctrl = '0; m_st = '0; m_inj_used = 0;
    endtask

    task automatic model_step();
        logic ev_c, ev_u, old_u;
        logic [1:0] w1c;
        ev_c  = m_rv & m_rc;
        ev_u  = m_rv & m_ru;
        old_u = m_st[1];
        w1c   = (reg_we && reg_addr == 3'd1) ? reg_wdata[1:0] : 2'b00;
        m_st  = (m_st & ~w1c) | {ev_u, ev_c};
        if ((ev_c || ev_u) && !old_u) begin
            m_laddr = m_raddr;
            m_lsyn  = m_rsyn;
        end
        if (reg_we && reg_addr == 3'd0) m_ctrl = reg_wdata[1:0];
        m_wv = wr_valid;
        if (wr_valid) begin
            m_inj_used = (m_mask != 0);
            m_wcode = bench_enc(wr_data) ^ m_mask;
            m_mask = '0;
        end
        if (reg_we && reg_addr == 3'd4) m_mask[31:0]  = reg_wdata;
        if (reg_we && reg_addr == 3'd5) m_mask[39:32] = reg_wdata[7:0];
        m_rv = rd_valid;
        m_rc = 0;
        m_ru = 0;
        if (rd_valid) begin
            m_raddr = rd_addr;
            m_rsyn  = {^rd_code, bench_ham(rd_code[31:0]) ^ rd_code[38:32]};
            m_rdata = rd_code[31:0];
            if (bench_enc(rd_code[31:0]) != rd_code) begin
                m_ru = 1;
                for (int b = 0; b < 40; b++) begin
                    logic [39:0] t;
                    t = rd_code ^ (40'd1 << b);
                    if (bench_enc(t[31:0]) == t) begin
                        m_ru = 0; m_rc = 1; m_rdata = t[31:0];
                    end
                end
            end
        end
    endtask

    function automatic logic [31:0] model_reg(input logic [2:0] a);
        case (a)
            3'd0: return {30'd0, m_ctrl};
            3'd1: return {30'd0, m_st};
            3'd2: return {16'd0, m_laddr};
            3'd3: return {24'd0, m_lsyn};
            3'd4: return m_mask[31:0];
            3'd5: return {24'd0, m_mask[39:32]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string rt, rgt;
        check("R1 wr_code_valid", 64'(wr_code_valid), 64'(m_wv));
        if (m_wv) check(m_inj_used ? "R8 wr_code injected" : "R1 wr_code", 64'(wr_code), 64'(m_wcode));
        rt = m_ru ? "R4" : (m_rc ? "R3" : "R2");
        check({rt, " rd_out_valid"}, 64'(rd_out_valid), 64'(m_rv));
        if (m_rv) begin
            check({rt, " rd_out_data"}, 64'(rd_out_data), 64'(m_rdata));
            check({rt, " rd_out_corr"}, 64'(rd_out_corr), 64'(m_rc));
            check({rt, " rd_out_uncorr"}, 64'(rd_out_uncorr), 64'(m_ru));
        end
        check("R7 irq", 64'(irq), 64'((m_st[0] & m_ctrl[0]) | (m_st[1] & m_ctrl[1])));
        case (reg_addr)
            3'd0:    rgt = "R7 ctrl reg";
            3'd1:    rgt = "R5 status reg";
            3'd2:    rgt = "R6 log addr reg";
            3'd3:    rgt = "R6 log syndrome reg";
            3'd4,
            3'd5:    rgt = "R8 mask reg";
            default: rgt = "R9 unused reg";
        endcase
        check(rgt, 64'(reg_rdata), 64'(model_reg(reg_addr)));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        wr_valid = 0; rd_valid = 0; reg_we = 0;
    endtask

    task automatic do_write(input logic [31:0] d);
        wr_valid = 1; wr_data = d; cyc();
    endtask

    task automatic do_read(input logic [15:0] a, input logic [39:0] c);
        rd_valid = 1; rd_addr = a; rd_code = c; cyc();
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d; cyc();
    endtask

    task automatic read_all();
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a); cyc();
        end
    endtask

    logic [31:0] seed = 32'h1234_5678;
    function automatic logic [31:0] next_rand();
        seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
        return seed;
    endfunction

    initial begin
        rst_n = 0; wr_valid = 0; wr_data = 0; rd_valid = 0; rd_addr = 0;
        rd_code = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        model_reset();
        repeat (3) @(negedge clk);
        // R9: reset state at the ports
        check("R9 wr_code_valid", 64'(wr_code_valid), 0);
        check("R9 rd_out_valid", 64'(rd_out_valid), 0);
        check("R9 irq", 64'(irq), 0);
        check("R9 reg0", 64'(reg_rdata), 0);
        rst_n = 1;
        read_all();

        // R1: encoding of assorted patterns, back to back
        do_write(32'h0000_0000);
        do_write(32'hFFFF_FFFF);
        do_write(32'hA5A5_5A5A);
        for (int i = 0; i < 32; i += 5) do_write(32'd1 << i);
        for (int i = 0; i < 6; i++) do_write(next_rand());

        // R2: clean words decode unchanged
        do_read(16'h0010, bench_enc(32'h0));
        do_read(16'h0011, bench_enc(32'hFFFF_FFFF));
        for (int i = 0; i < 6; i++) do_read(16'(i + 32), bench_enc(next_rand()));
        read_all();

        // R3/R7: every single-bit position, corrected-error interrupt enabled
        reg_write(3'd0, 32'd1);
        for (int b = 0; b < 40; b++) do_read(16'(16'h100 + b), bench_enc(next_rand()) ^ (40'd1 << b));
        read_all();

        // R5: clear the corrected flag, interrupt drops
        reg_write(3'd1, 32'd1);
        read_all();

        // R4/R6: double errors, first one kept in the log
        reg_write(3'd0, 32'd3);
        do_read(16'h0200, bench_enc(next_rand()) ^ 40'h3);
        do_read(16'h0201, bench_enc(next_rand()) ^ ((40'd1 << 5) | (40'd1 << 38)));
        do_read(16'h0202, bench_enc(next_rand()) ^ ((40'd1 << 39) | (40'd1 << 12)));
        do_read(16'h0203, bench_enc(next_rand()) ^ ((40'd1 << 32) | (40'd1 << 33)));
        do_read(16'h0204, bench_enc(next_rand()) ^ (40'd1 << 7));
        read_all();

        // R5: clear both flags in the same cycle as a new event arrives
        do_read(16'h0300, bench_enc(next_rand()) ^ (40'd1 << 20));
        reg_write(3'd1, 32'd3);
        read_all();
        reg_write(3'd1, 32'd3);
        do_read(16'h0301, bench_enc(next_rand()) ^ (40'd1 << 35));
        read_all();

        // R8: one-shot injection mask
        reg_write(3'd4, 32'h0000_0080);
        reg_write(3'd5, 32'h0000_0080);
        read_all();
        do_write(32'hDEAD_BEEF);
        do_write(32'hCAFE_F00D);
        read_all();
        do_read(16'h0400, bench_enc(32'hDEAD_BEEF) ^ ((40'd1 << 7) | (40'd1 << 39)));

        // R8: mask write in the same cycle as a write
        reg_write(3'd4, 32'h0000_0001);
        wr_valid = 1; wr_data = 32'h1111_2222; reg_we = 1; reg_addr = 3'd4; reg_wdata = 32'h0000_0100;
        cyc();
        read_all();
        do_write(32'h3333_4444);
        do_write(32'h5555_6666);
        read_all();

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule